// File: doc/BRIEF.md
# SMII transmit segment deserializer

This block sits on the PHY side of a serial media-independent link. It recovers the transmit bytes that a MAC sends over one serial data line. The line is sampled on every rising edge of the core clock. A one-clock sync pulse marks the first bit of each 10-bit segment. Each segment unpacks into an error flag, an enable flag and a data byte. A segment whose enable flag is low carries no byte.

In 100 Mb/s operation every segment delivers a new byte. In 10 Mb/s operation the MAC repeats each byte over a group of ten segments. A free-running segment counter picks one segment of the group, the fifth by default, and captures the byte there. A parameter chooses, at elaboration, the clock and sync pair that drives the logic. The block can use either the shared reference pair or a dedicated transmit pair, and the unselected pair has no effect.

Top module: `smii_tx_deser`

## Requirements
- R1: A synchronous active-high reset clears the bit position, the alignment state and the segment counter. It also forces `byte_vld`, `byte_en`, `byte_err` and `byte_data` to 0, and the block delivers nothing until a new sync arrives.
- R2: A segment is 10 bits on consecutive clocks, in this order: error flag (the bit sampled with sync high), enable flag, then data bits 0 to 7, least significant bit first. `byte_err`, `byte_en` and `byte_data` report the three fields of the captured segment.
- R3: In 100 Mb/s mode (`mode_10m` = 0) every segment with the enable flag set raises `byte_vld` for exactly one clock. That clock follows the edge that samples the segment's last bit. No strobe occurs at any other time.
- R4: A captured segment with the enable flag low gives no strobe and leaves `byte_data` unchanged. `byte_en` reads 0 and `byte_err` reads the segment's error flag.
- R5: A sync pulse at any spacing restarts the bit position, so the sampled bit becomes the error flag of a new segment. The bits already received for the interrupted segment are discarded and produce no strobe.
- R6: After the first sync, segments keep being decoded every 10 clocks when no further sync arrives. Before the first sync after reset, no segment is decoded.
- R7: In 10 Mb/s mode (`mode_10m` = 1) a segment counter cycles through `REPEAT` (10) segments. Only the segment at position `PICK` (5, counting from 1) of each group is captured. The other segments of the group have no effect on the outputs.
- R8: A change of `mode_10m` clears the segment counter. The segment that completes first after the change counts as position 1 of a new group.
- R9: With `SRC_SYNC` = 0 the logic runs on `ref_clk`/`ref_sync`. With `SRC_SYNC` = 1 it runs on `tx_clk`/`tx_sync`. In each case the other clock and sync inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Shared reference clock (used when SRC_SYNC = 0) |
| ref_sync | input | 1 | Shared segment sync pulse (used when SRC_SYNC = 0) |
| tx_clk | input | 1 | Dedicated transmit clock (used when SRC_SYNC = 1) |
| tx_sync | input | 1 | Dedicated transmit sync pulse (used when SRC_SYNC = 1) |
| rst | input | 1 | Synchronous active-high reset |
| mode_10m | input | 1 | 1 selects 10 Mb/s capture, 0 selects 100 Mb/s |
| ser_d | input | 1 | Serial transmit data line |
| byte_vld | output | 1 | One-clock strobe for a delivered byte |
| byte_data | output | DATA_W | Captured data byte |
| byte_en | output | 1 | Enable flag of the captured segment |
| byte_err | output | 1 | Error flag of the captured segment |

## Verification
The bench builds two copies with the default 8-bit data, a group of ten and a pick position of five. One copy uses the reference pair and the other uses the dedicated transmit pair, and the unused pair of each is driven with a toggling pattern. They share one serial stream, so every segment also compares the two variants. The small data width lets the bench sweep all 256 byte values with the enable flag set, plus a spread of values with it clear. In 10 Mb/s mode each segment of a group carries a different byte, so a wrong pick position shows up at once. The bench also covers every early-sync length from one to nine bits, mode changes in the middle of a group, and a reset in the middle of a segment.

// File: rtl/smii_tx_deser.sv
module smii_tx_deser #(
  parameter int DATA_W   = 8,
  parameter int REPEAT   = 10,
  parameter int PICK     = 5,
  parameter bit SRC_SYNC = 1'b0
) (
  input  logic              ref_clk,
  input  logic              ref_sync,
  input  logic              tx_clk,
  input  logic              tx_sync,
  input  logic              rst,
  input  logic              mode_10m,
  input  logic              ser_d,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_en,
  output logic              byte_err
);
  localparam int SEG_W = DATA_W + 2;
  localparam int PW    = $clog2(SEG_W);
  localparam int CW    = (REPEAT > 1) ? $clog2(REPEAT) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(SEG_W - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(REPEAT - 1);
  localparam logic [CW-1:0] PICK_CNT = CW'(PICK - 1);

  logic core_clk, core_sync;
  assign core_clk  = SRC_SYNC ? tx_clk  : ref_clk;
  assign core_sync = SRC_SYNC ? tx_sync : ref_sync;

  logic [PW-1:0]    pos, cur;
  logic             aligned;
  logic [SEG_W-2:0] seg;
  logic             mode_q;
  logic [CW-1:0]    seg_cnt;

  assign cur = core_sync ? '0 : pos;

  logic last, mode_chg, pick, take;
  assign last     = (aligned | core_sync) && (cur == LAST_POS);
  assign mode_chg = mode_10m != mode_q;
  assign pick     = !mode_10m || (seg_cnt == PICK_CNT && !mode_chg);
  assign take     = last && pick;

  always_ff @(posedge core_clk) begin
    if (rst) begin
      pos       <= '0;
      aligned   <= 1'b0;
      seg       <= '0;
      mode_q    <= mode_10m;
      seg_cnt   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_en   <= 1'b0;
      byte_err  <= 1'b0;
    end else begin
      pos     <= (cur == LAST_POS) ? '0 : cur + PW'(1);
      aligned <= aligned | core_sync;
      if (cur != LAST_POS) seg[cur] <= ser_d;
      mode_q  <= mode_10m;
      if (mode_chg)
        seg_cnt <= '0;
      else if (last && mode_10m)
        seg_cnt <= (seg_cnt == LAST_CNT) ? '0 : seg_cnt + CW'(1);
      byte_vld <= take && seg[1];
      if (take) begin
        byte_err <= seg[0];
        byte_en  <= seg[1];
        if (seg[1]) byte_data <= {ser_d, seg[SEG_W-2:2]};
      end
    end
  end
endmodule

// File: rtl/smii_tx_deser_chk.sv
module smii_tx_deser_chk #(
  parameter int DATA_W = 8,
  parameter int REPEAT = 10,
  parameter int PICK   = 5,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_10m,
  input logic              byte_vld,
  input logic              byte_en,
  input logic [DATA_W-1:0] byte_data,
  input logic [CW-1:0]     seg_cnt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !byte_vld);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R4
  strobe_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> byte_en);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_data != $past(byte_data)) |-> byte_vld);

  // R7
  pick_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && $past(mode_10m) && mode_10m) |-> (seg_cnt == CW'(PICK % REPEAT)));

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_10m != $past(mode_10m)) |=> (seg_cnt == '0));
endmodule

bind smii_tx_deser smii_tx_deser_chk #(
  .DATA_W(DATA_W), .REPEAT(REPEAT), .PICK(PICK), .CW(CW)
) u_chk (
  .clk(core_clk), .rst(rst), .mode_10m(mode_10m), .byte_vld(byte_vld),
  .byte_en(byte_en), .byte_data(byte_data), .seg_cnt(seg_cnt)
);

// File: tb/test_smii_tx_deser.sv
`timescale 1ns/1ps
module test_smii_tx_deser;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, mode = 1'b0, sd = 1'b0, sync = 1'b0, junk = 1'b0;
  logic       v_m, en_m, er_m, v_s, en_s, er_s;
  logic [7:0] d_m, d_s;
  int checks = 0, errors = 0;
  logic [7:0] exp_data = 8'h00;

  smii_tx_deser i_smii_tx_deser (
    .ref_clk(clk), .ref_sync(sync), .tx_clk(1'b0), .tx_sync(junk),
    .rst(rst), .mode_10m(mode), .ser_d(sd),
    .byte_vld(v_m), .byte_data(d_m), .byte_en(en_m), .byte_err(er_m));

  smii_tx_deser #(.SRC_SYNC(1'b1)) i_smii_tx_deser_ss (
    .ref_clk(1'b0), .ref_sync(junk), .tx_clk(clk), .tx_sync(sync),
    .rst(rst), .mode_10m(mode), .ser_d(sd),
    .byte_vld(v_s), .byte_data(d_s), .byte_en(en_s), .byte_err(er_s));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one segment; returns outputs sampled after its last bit, plus stray strobes and variant mismatch
  task automatic send_seg(input bit err, input bit en, input logic [7:0] d, input bit with_sync,
                          output bit stray, output bit mism, output logic [10:0] res);
    logic [9:0] bits;
    bits = {d, en, err};
    stray = 1'b0; mism = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sd = bits[i]; sync = with_sync && (i == 0); junk = ~junk;
      @(posedge clk); #1;
      if (i < 9) stray |= v_m;
      if ({v_m, en_m, er_m, d_m} !== {v_s, en_s, er_s, d_s}) mism = 1'b1;
    end
    res = {v_m, en_m, er_m, d_m};
  endtask

  task automatic send_part(input int n, output bit stray);
    stray = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sd = i[0]; sync = (i == 0); junk = ~junk;
      @(posedge clk); #1;
      stray |= v_m;
    end
  endtask

  task automatic seg_expect(input string req, input bit err, input bit en, input logic [7:0] d,
                            input bit with_sync, input bit exp_v);
    bit st, mm; logic [10:0] r, e;
    send_seg(err, en, d, with_sync, st, mm, r);
    if (exp_v) exp_data = d;
    e = {exp_v, exp_v ? 1'b1 : r[9], exp_v ? err : r[8], exp_data};
    check(!st && r === e, req, {st, r}, e);
    check(!mm, "R9", mm, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit st, mm; logic [10:0] r;
    repeat (5) @(posedge clk);
    #1;
    // R1: reset state
    check({v_m, en_m, er_m, d_m} === 11'h0, "R1", {v_m, en_m, er_m, d_m}, 0);
    rst = 1'b0;

    // R6: no decoding before the first sync
    for (int k = 0; k < 2; k++) begin
      send_seg(1'b0, 1'b1, 8'hA5, 1'b0, st, mm, r);
      check(!st && !r[10], "R6", {st, r[10]}, 0);
    end

    // R2 R3: all byte values, enabled
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = 8'(i);
      seg_expect("R3", d[0] ^ d[7], 1'b1, d, 1'b1, 1'b1);
    end
    // R2: field order with single bits set
    for (int i = 0; i < 8; i++) seg_expect("R2", 1'b0, 1'b1, 8'(1 << i), 1'b1, 1'b1);
    seg_expect("R2", 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);

    // R4: enable low drops the byte, err still reported
    for (int i = 0; i < 256; i += 17) begin
      send_seg(i[0], 1'b0, 8'(i), 1'b1, st, mm, r);
      check(!st && r === {1'b0, 1'b0, i[0], exp_data}, "R4", r, {1'b0, 1'b0, i[0], exp_data});
    end

    // R6: free run without sync
    for (int i = 0; i < 8; i++) seg_expect("R6", 1'b0, 1'b1, 8'(8'h30 + i), 1'b0, 1'b1);

    // R5: early sync after every partial length
    for (int n = 1; n < 10; n++) begin
      send_part(n, st);
      check(!st, "R5", st, 0);
      seg_expect("R5", 1'b0, 1'b1, 8'(8'hC0 + n), 1'b1, 1'b1);
    end

    // R7: 10 Mb/s picks the 5th segment of each group
    mode = 1'b1;
    for (int g = 0; g < 30; g++) begin
      for (int k = 0; k < 10; k++) begin
        bit en = !((g == 3 && k == 4) || (g == 5 && k != 4));
        seg_expect(g == 3 ? "R4" : "R7", 1'b0, en, 8'(g * 10 + k), k == 0, k == 4 && en);
      end
    end

    // R8: leave 10 Mb/s mid-group and come back
    for (int k = 0; k < 2; k++) seg_expect("R8", 1'b0, 1'b1, 8'(8'h70 + k), 1'b1, 1'b0);
    mode = 1'b0;
    seg_expect("R8", 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1);
    mode = 1'b1;
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 10; k++)
        seg_expect("R8", 1'b1, 1'b1, 8'(8'h90 + g * 10 + k), 1'b1, k == 4);
    mode = 1'b0;

    // R1: reset mid-segment clears outputs and alignment
    send_part(4, st);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check({v_m, en_m, er_m, d_m} === 11'h0, "R1", {v_m, en_m, er_m, d_m}, 0);
    rst = 1'b0;
    exp_data = 8'h00;
    send_seg(1'b0, 1'b1, 8'h3C, 1'b0, st, mm, r);
    check(!st && !r[10], "R1", {st, r[10]}, 0);
    seg_expect("R3", 1'b0, 1'b1, 8'h3C, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule